// File: doc/BRIEF.md
# Serial Memory Status and Write-Protect Unit

This unit holds the status byte of a byte-addressed serial memory and decides, cycle by cycle, whether a status-register write or an array write may proceed. A command decoder outside the unit hands it single-cycle strobes: set the write-enable latch, clear it, or load the status byte with a data byte. A write path outside the unit also presents the target address of each array write. The unit answers each request in the same cycle with an allow flag, and it presents the status byte for read-out.

Two protection levels are layered. In software protection, the write-protect pin is high. Two block-protect bits then select a protected top slice of the array, and a status write with the latch set may change them. In hardware protection, the pin is low while the status-write-disable bit is 1. The unit then refuses every status write, so the block-protect bits and the disable bit stay frozen until the pin goes high again. The serial shifter and the memory array lie outside this unit.

Top module: `statprot_unit`

## Requirements
- R1: After reset the status byte reads 00h, so the write-enable latch (bit 1) is clear.
- R2: A set-latch strobe makes bit 1 read 1 from the next cycle on, and a clear-latch strobe makes it read 0. When both strobes come in the same cycle, clear wins.
- R3: Status byte layout: bit 7 is the write-disable bit SRWD, bit 3 is BP1, bit 2 is BP0 and bit 1 is the latch. Bits 6..4 and bit 0 always read 0.
- R4: `statWrAllow` is high exactly when `cmdStatWrite` is high, the latch is 1, and the unit is not hardware protected. When it is high, bits 7, 3 and 2 take data bits 7, 3 and 2 in the next cycle, and the other data bits are ignored.
- R5: A status write, accepted or not, leaves the write-enable latch unchanged.
- R6: While `wpN` is 0 and SRWD is 1, status writes are refused and SRWD, BP1 and BP0 keep their values. The refusal ends only when `wpN` returns to 1.
- R7: While `wpN` is 1, a status write with the latch set is accepted whatever the value of SRWD.
- R8: `memWrAllow` is high only when `memWrReq` is high and the latch is 1.
- R9: The protected range follows BP1:BP0. 00 protects nothing. 01 protects the top quarter (the two address MSBs are 11). 10 protects the top half (the address MSB is 1). 11 protects every address. An array write into a protected address gets `memWrAllow` low.
- R10: An array write or a status write in the same cycle as a latch or status command is judged against the status held before that cycle's commands take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wpN | input | 1 | Write-protect pin, low asserts protection |
| cmdWrEnable | input | 1 | Set-latch strobe |
| cmdWrDisable | input | 1 | Clear-latch strobe |
| cmdStatWrite | input | 1 | Status-write strobe |
| statWrData | input | 8 | Data byte of the status write |
| memWrReq | input | 1 | Array write request |
| memWrAddr | input | ADDR_W | Target address of the array write |
| statusByte | output | 8 | Status byte for reads |
| statWrAllow | output | 1 | Status write accepted this cycle |
| memWrAllow | output | 1 | Array write allowed this cycle |

## Verification
An array write request and a latch or status command can fall in the same cycle. The array write must then be judged against the old latch and block-protect bits, while the command takes effect one edge later. The bench provokes this with a clear-latch strobe beside an allowed array write, and with a status write that raises BP1:BP0 to 11 beside an array write to the bottom address. Random cycles then set all strobes and the request independently. The bench reference model updates state only after it has formed that cycle's expected allow flags, and each flag is compared before the edge.

// File: rtl/statprot_pkg.sv
package statprot_pkg;
  localparam int STAT_W    = 8;
  localparam int SRWD_POS  = 7;
  localparam int BP1_POS   = 3;
  localparam int BP0_POS   = 2;
  localparam int WEL_POS   = 1;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadStat;
  } statCtl_t;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } protSel_t;
endpackage

// File: rtl/statprot_ctrl.sv
module statprot_ctrl
  import statprot_pkg::*;
(
  input  logic     wpN,
  input  logic     cmdWrEnable,
  input  logic     cmdWrDisable,
  input  logic     cmdStatWrite,
  input  logic     welNow,
  input  logic     srwdNow,
  output statCtl_t ctl,
  output logic     statWrAllow
);
  logic hwLocked;

  // hardware protection: pin low and disable bit set
  assign hwLocked = !wpN && srwdNow;

  always_comb begin
    statWrAllow  = cmdStatWrite && welNow && !hwLocked;
    ctl.loadStat = statWrAllow;
    ctl.clrWel   = cmdWrDisable;
    ctl.setWel   = cmdWrEnable && !cmdWrDisable;
  end
endmodule

// File: rtl/statprot_dp.sv
module statprot_dp
  import statprot_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  statCtl_t          ctl,
  input  logic              newSrwd,
  input  logic [1:0]        newBp,
  input  logic              memWrReq,
  input  logic [ADDR_W-1:0] memWrAddr,
  output logic              welNow,
  output logic              srwdNow,
  output logic [STAT_W-1:0] statusByte,
  output logic              memWrAllow
);
  localparam int TOP_BITS = 2;

  logic       welQ;
  logic       srwdQ;
  logic [1:0] bpQ;
  logic [TOP_BITS-1:0] topAddr;
  logic       inRange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ <= 1'b0;
    end else if (ctl.clrWel) begin
      welQ <= 1'b0;
    end else if (ctl.setWel) begin
      welQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srwdQ <= 1'b0;
      bpQ   <= 2'b00;
    end else if (ctl.loadStat) begin
      srwdQ <= newSrwd;
      bpQ   <= newBp;
    end
  end

  assign topAddr = memWrAddr[ADDR_W-1 -: TOP_BITS];

  always_comb begin
    unique case (protSel_t'(bpQ))
      PROT_NONE:    inRange = 1'b0;
      PROT_QUARTER: inRange = &topAddr;
      PROT_HALF:    inRange = topAddr[TOP_BITS-1];
      default:      inRange = 1'b1;
    endcase
  end

  assign memWrAllow = memWrReq && welQ && !inRange;
  assign welNow     = welQ;
  assign srwdNow    = srwdQ;

  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    if (b == SRWD_POS) begin : g_srwd
      assign statusByte[b] = srwdQ;
    end else if (b == BP1_POS) begin : g_bp1
      assign statusByte[b] = bpQ[1];
    end else if (b == BP0_POS) begin : g_bp0
      assign statusByte[b] = bpQ[0];
    end else if (b == WEL_POS) begin : g_wel
      assign statusByte[b] = welQ;
    end else begin : g_zero
      assign statusByte[b] = 1'b0;
    end
  end
endmodule

// File: rtl/statprot_unit.sv
module statprot_unit
  import statprot_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpN,
  input  logic              cmdWrEnable,
  input  logic              cmdWrDisable,
  input  logic              cmdStatWrite,
  input  logic [7:0]        statWrData,
  input  logic              memWrReq,
  input  logic [ADDR_W-1:0] memWrAddr,
  output logic [7:0]        statusByte,
  output logic              statWrAllow,
  output logic              memWrAllow
);
  statCtl_t ctl;
  logic     welNow;
  logic     srwdNow;
  logic     unusedDataBits;

  assign unusedDataBits = ^{statWrData[6:4], statWrData[1:0]};

  statprot_ctrl i_ctrl (
    .wpN          (wpN),
    .cmdWrEnable  (cmdWrEnable),
    .cmdWrDisable (cmdWrDisable),
    .cmdStatWrite (cmdStatWrite),
    .welNow       (welNow),
    .srwdNow      (srwdNow),
    .ctl          (ctl),
    .statWrAllow  (statWrAllow)
  );

  statprot_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .newSrwd    (statWrData[SRWD_POS]),
    .newBp      (statWrData[BP1_POS:BP0_POS]),
    .memWrReq   (memWrReq),
    .memWrAddr  (memWrAddr),
    .welNow     (welNow),
    .srwdNow    (srwdNow),
    .statusByte (statusByte),
    .memWrAllow (memWrAllow)
  );
endmodule

// File: rtl/statprot_chk.sv
module statprot_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              wpN,
  input logic              cmdWrEnable,
  input logic              cmdWrDisable,
  input logic              cmdStatWrite,
  input logic [7:0]        statWrData,
  input logic              memWrReq,
  input logic [ADDR_W-1:0] memWrAddr,
  input logic [7:0]        statusByte,
  input logic              statWrAllow,
  input logic              memWrAllow
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> statusByte == 8'h00);

  assert_wel_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrEnable && !cmdWrDisable |=> statusByte[1]);

  assert_wel_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrDisable |=> !statusByte[1]);

  assert_zero_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6:4] == 3'b000 && !statusByte[0]);

  assert_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    statWrAllow |=> statusByte[7] == $past(statWrData[7]) &&
                    statusByte[3:2] == $past(statWrData[3:2]));

  assert_allow_needs_wel_R4: assert property (@(posedge clk) disable iff (!rstN)
    statWrAllow |-> statusByte[1] && cmdStatWrite);

  assert_wel_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdStatWrite && !cmdWrEnable && !cmdWrDisable |=> $stable(statusByte[1]));

  assert_hw_freeze_R6: assert property (@(posedge clk) disable iff (!rstN)
    !wpN && statusByte[7] |=> $stable(statusByte[7]) && $stable(statusByte[3:2]));

  assert_sw_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    wpN && cmdStatWrite && statusByte[1] |-> statWrAllow);

  assert_mem_wel_R8: assert property (@(posedge clk) disable iff (!rstN)
    memWrAllow |-> memWrReq && statusByte[1]);

  assert_range_all_R9: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[3:2] == 2'b11 |-> !memWrAllow);

  assert_range_half_R9: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[3:2] == 2'b10 && memWrAddr[ADDR_W-1] |-> !memWrAllow);
endmodule

bind statprot_unit statprot_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wpN          (wpN),
  .cmdWrEnable  (cmdWrEnable),
  .cmdWrDisable (cmdWrDisable),
  .cmdStatWrite (cmdStatWrite),
  .statWrData   (statWrData),
  .memWrReq     (memWrReq),
  .memWrAddr    (memWrAddr),
  .statusByte   (statusByte),
  .statWrAllow  (statWrAllow),
  .memWrAllow   (memWrAllow)
);

// File: tb/test_statprot_unit.sv
module test_statprot_unit;
  localparam int ADDR_W = 15;
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wpN = 1'b1;
  logic cmdWrEnable = 1'b0, cmdWrDisable = 1'b0, cmdStatWrite = 1'b0;
  logic [7:0] statWrData = 8'h00;
  logic memWrReq = 1'b0;
  logic [ADDR_W-1:0] memWrAddr = '0;
  logic [7:0] statusByte;
  logic statWrAllow, memWrAllow;

  int checks = 0;
  int errors = 0;
  logic mWel = 1'b0, mSrwd = 1'b0;
  logic [1:0] mBp = 2'b00;

  always #10 clk = ~clk;

  statprot_unit #(.ADDR_W(ADDR_W)) i_statprot_unit (
    .clk(clk), .rstN(rstN), .wpN(wpN),
    .cmdWrEnable(cmdWrEnable), .cmdWrDisable(cmdWrDisable),
    .cmdStatWrite(cmdStatWrite), .statWrData(statWrData),
    .memWrReq(memWrReq), .memWrAddr(memWrAddr),
    .statusByte(statusByte), .statWrAllow(statWrAllow),
    .memWrAllow(memWrAllow)
  );

  function automatic logic isProt(logic [1:0] bp, logic [ADDR_W-1:0] a);
    case (bp)
      2'b00: return 1'b0;
      2'b01: return a[ADDR_W-1] && a[ADDR_W-2];
      2'b10: return a[ADDR_W-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] expStatus();
    return {mSrwd, 3'b000, mBp, mWel, 1'b0};
  endfunction

  task automatic check(input logic ok, input string req, input string ctx,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) actual=%0h expected=%0h", req, ctx, act, exp);
    end
  endtask

  // one cycle: called just after a falling edge
  task automatic step(input logic en, input logic dis, input logic sw,
                      input logic [7:0] d, input logic mreq,
                      input logic [ADDR_W-1:0] a, input logic wp,
                      input string ctx);
    logic expS, expM;
    check(statusByte === expStatus(), "R3", ctx, statusByte, expStatus());
    cmdWrEnable = en; cmdWrDisable = dis; cmdStatWrite = sw;
    statWrData = d; memWrReq = mreq; memWrAddr = a; wpN = wp;
    #5;
    // R10: expected flags use the status held before this cycle
    expS = sw && mWel && !(!wp && mSrwd);
    expM = mreq && mWel && !isProt(mBp, a);
    check(statWrAllow === expS, (!wp && mSrwd) ? "R6" : "R4", ctx, statWrAllow, expS);
    check(memWrAllow === expM, mWel ? "R9" : "R8", ctx, memWrAllow, expM);
    if (expS) begin
      mSrwd = d[7];
      mBp = d[3:2];
    end
    if (dis) mWel = 1'b0;
    else if (en) mWel = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    repeat (2) @(negedge clk);
    check(statusByte === 8'h00, "R1", "reset", statusByte, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    step(0,0,1,8'h8C,0,'0,1,"R4 write refused with latch clear");
    step(0,0,0,8'h00,1,'0,1,"R8 array write with latch clear");
    step(1,0,0,8'h00,0,'0,1,"R2 set latch");
    step(0,0,1,8'hFF,1,TOP_ADDR,1,"R7 status write SRWD=1 BP=11 with wp high");
    step(0,0,0,8'h00,1,'0,1,"R9 all protected");
    step(0,0,1,8'h04,0,'0,0,"R6 hardware protected write refused");
    step(0,0,1,8'h00,0,'0,0,"R6 still frozen");
    step(0,0,1,8'h04,0,'0,1,"R7 wp high again, BP=01 SRWD=0");
    step(0,0,0,8'h00,1,TOP_ADDR,1,"R9 quarter top refused");
    step(0,0,0,8'h00,1,{2'b10,{(ADDR_W-2){1'b1}}},1,"R9 quarter below ok");
    step(0,0,1,8'h08,1,TOP_ADDR,0,"R9 wp low SRWD=0 still writable");
    step(0,0,0,8'h00,1,{1'b0,{(ADDR_W-1){1'b1}}},1,"R9 half lower ok");
    step(0,0,1,8'h0C,1,'0,1,"R10 status write beside array write");
    step(0,0,1,8'h00,0,'0,1,"R5 clear BP, latch kept");
    step(0,1,0,8'h00,1,'0,1,"R10 clear latch beside allowed write");
    step(1,1,0,8'h00,1,'0,1,"R2 both strobes, clear wins");
    step(1,0,0,8'h00,0,'0,1,"R2 set again");
    step(0,0,1,8'h73,0,'0,1,"R3 ignored data bits");
    step(0,0,0,8'h00,0,'0,1,"R3 readback");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[2] & r[3] & r[4], r[5], $urandom, r[6],
           $urandom, r[8] | r[9], "random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule